// File: doc/BRIEF.md
# Write-Once System Options Register with Watchdog and Stop Guard

This block holds an 8-bit system configuration register on a simple memory-mapped bus. The register accepts only the first write after reset. After that write it is locked, so a stray store cannot change the safety settings again until the next reset. Boot code is expected to write the register once, even if the value it wants matches the defaults.

Three functions read their settings from this register:

- **Watchdog timer.** It counts bus clocks and asks for a system reset if software does not service it in time. One bit enables it and another bit picks a short or a long timeout.
- **Stop guard.** A low-power stop request either goes ahead or, when stop mode is not enabled, becomes an illegal-operation reset request.
- **Debug-pin select.** One bit chooses whether a shared pin serves as the debug/mode pin or as a general-purpose output.

Each of the two timeout lengths is a power of two of bus clocks. The exponents are parameters.

Top module: `sysopt_guard`

## Requirements
- R1: After reset the register reads 0xC2. Bit 7 (watchdog enable) = 1, bit 6 (long timeout) = 1, bit 1 (debug-pin function) = 1, and every other bit = 0.
- R2: The first write with `sel_i` and `wr_i` high after reset is stored and sets the lock, even if the written value equals the reset value. Every later write is ignored until the next reset.
- R3: Bits 3 and 2 always read 0, whatever value was written.
- R4: Bits 4 and 0 store the written value and read it back.
- R5: While bit 7 = 1, the watchdog counts one step per clock. `wdog_rst_o` pulses for one cycle every 2^LONG_EXP clocks when bit 6 = 1, and every 2^SHORT_EXP clocks when bit 6 = 0. The count starts from reset or from the last pulse.
- R6: While bit 7 = 0, the counter is held at zero and `wdog_rst_o` stays low.
- R7: A one-cycle `svc_i` pulse restarts the count from zero. A service in the same cycle as the terminal count suppresses that pulse.
- R8: One cycle after `stop_req_i`, the block raises `ill_rst_o` if bit 5 (stop enable) = 0, or `stop_enter_o` if bit 5 = 1. The decision uses the register value held before any write made in the same cycle.
- R9: `dbg_pin_sel_o` equals bit 1. It returns to 1 on every reset.
- R10: `rdata_o` shows the register when `sel_i` and `rd_i` are both high, and 0 otherwise. A read is possible at any time, locked or not.
- R11: Reset clears the lock and the watchdog counter. A write presented while reset is active is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register address select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not selected for a read |
| svc_i | input | 1 | Watchdog service strobe |
| stop_req_i | input | 1 | Request to enter stop mode |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |
| ill_rst_o | output | 1 | Illegal-operation reset request |
| stop_enter_o | output | 1 | Permission to enter stop mode |
| dbg_pin_sel_o | output | 1 | 1 = debug/mode pin function, 0 = general-purpose output |

## Verification
Two pairs of events can land in the same clock, and the bench drives both deliberately.

- **Service at the terminal count.** The bench waits until its own model's counter reaches the terminal value, then raises `svc_i` in exactly that cycle. It then checks that no watchdog pulse appears and that the count starts again from zero.
- **Write together with a stop request.** A write that sets stop enable is issued in the same cycle as a stop request. The bench checks that the request is still judged against the old value and gives an illegal-operation reset. A second request afterwards must be allowed.

The short and long timeout exponents are reduced in the bench, so that whole timeout periods fit within the run.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
   localparam int unsigned OPT_W        = 8;
   localparam int unsigned BIT_WDOG_EN  = 7;
   localparam int unsigned BIT_WDOG_LNG = 6;
   localparam int unsigned BIT_STOP_EN  = 5;
   localparam int unsigned BIT_DBG_PIN  = 1;
   localparam logic [OPT_W-1:0] OPT_RESET = 8'hC2;
   localparam logic [OPT_W-1:0] OPT_IMPL  = 8'hF3;

   typedef logic [OPT_W-1:0] opt_word_t;

   typedef enum logic {
      TO_SHORT = 1'b0,
      TO_LONG  = 1'b1
   } timeout_sel_e;
endpackage

// File: rtl/sysopt_reg.sv
module sysopt_reg #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] IMPL    = '1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_stb_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cfg_o,
   output logic         locked_o
);
   logic take;
   assign take = wr_stb_i && !locked_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) locked_o <= 1'b0;
      else if (take) locked_o <= 1'b1;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_store
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= RST_VAL[b];
            else if (take) q <= wdata_i[b];
         end
         assign cfg_o[b] = q;
      end else begin : g_zero
         assign cfg_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/sysopt_wdog.sv
module sysopt_wdog #(
   parameter int unsigned SHORT_EXP = 13,
   parameter int unsigned LONG_EXP  = 18
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   input  logic                long_i,
   input  logic                svc_i,
   output logic [LONG_EXP-1:0] cnt_o,
   output logic                expire_o
);
   localparam int unsigned CW = LONG_EXP;
   localparam logic [CW-1:0] TERM_LONG  = {CW{1'b1}};
   localparam logic [CW-1:0] TERM_SHORT = CW'({SHORT_EXP{1'b1}});

   logic [CW-1:0] term;
   logic          hit;

   always_comb begin
      unique case (sysopt_pkg::timeout_sel_e'(long_i))
         sysopt_pkg::TO_LONG:  term = TERM_LONG;
         default:              term = TERM_SHORT;
      endcase
   end

   assign hit      = (cnt_o >= term);
   assign expire_o = en_i && !svc_i && hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o <= '0;
      else if (!en_i || svc_i || hit) cnt_o <= '0;
      else cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/sysopt_stop_guard.sv
module sysopt_stop_guard (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stop_req_i,
   input  logic stop_en_i,
   output logic ill_rst_o,
   output logic stop_go_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ill_rst_o <= 1'b0;
         stop_go_o <= 1'b0;
      end else begin
         ill_rst_o <= stop_req_i && !stop_en_i;
         stop_go_o <= stop_req_i && stop_en_i;
      end
   end
endmodule

// File: rtl/sysopt_guard.sv
module sysopt_guard #(
   parameter int unsigned SHORT_EXP = 13,
   parameter int unsigned LONG_EXP  = 18
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sel_i,
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o,
   input  logic       svc_i,
   input  logic       stop_req_i,
   output logic       wdog_rst_o,
   output logic       ill_rst_o,
   output logic       stop_enter_o,
   output logic       dbg_pin_sel_o
);
   import sysopt_pkg::*;

   if (SHORT_EXP < 1) begin : g_bad_short
      $error("SHORT_EXP must be at least 1");
   end
   if (SHORT_EXP >= LONG_EXP) begin : g_bad_order
      $error("SHORT_EXP must be below LONG_EXP");
   end

   opt_word_t           cfg_q;
   logic                lock_q;
   logic [LONG_EXP-1:0] wd_cnt;

   sysopt_reg #(
      .W      (OPT_W),
      .IMPL   (OPT_IMPL),
      .RST_VAL(OPT_RESET)
   ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_stb_i(sel_i && wr_i),
      .wdata_i (wdata_i),
      .cfg_o   (cfg_q),
      .locked_o(lock_q)
   );

   sysopt_wdog #(
      .SHORT_EXP(SHORT_EXP),
      .LONG_EXP (LONG_EXP)
   ) u_wdog (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cfg_q[BIT_WDOG_EN]),
      .long_i  (cfg_q[BIT_WDOG_LNG]),
      .svc_i   (svc_i),
      .cnt_o   (wd_cnt),
      .expire_o(wdog_rst_o)
   );

   sysopt_stop_guard u_stop (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stop_req_i(stop_req_i),
      .stop_en_i (cfg_q[BIT_STOP_EN]),
      .ill_rst_o (ill_rst_o),
      .stop_go_o (stop_enter_o)
   );

   assign rdata_o       = (sel_i && rd_i) ? cfg_q : '0;
   assign dbg_pin_sel_o = cfg_q[BIT_DBG_PIN];
endmodule

// File: rtl/sysopt_guard_chk.sv
module sysopt_guard_chk #(
   parameter int unsigned LONG_EXP = 18
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                sel_i,
   input logic                wr_i,
   input logic                svc_i,
   input logic                stop_req_i,
   input logic [7:0]          rdata_o,
   input logic                wdog_rst_o,
   input logic                ill_rst_o,
   input logic                stop_enter_o,
   input logic [7:0]          cfg,
   input logic                locked,
   input logic [LONG_EXP-1:0] cnt
);
   // R2: once locked, a write leaves the register unchanged
   a_r2_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked && sel_i && wr_i) |=> $stable(cfg));

   // R3: unimplemented bits never read as 1
   a_r3_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[3:2] == 2'b00);

   // R5: the watchdog request is a single-cycle pulse
   a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdog_rst_o |=> !wdog_rst_o);

   // R6: a disabled watchdog holds its count at zero and stays silent
   a_r6_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg[7] |=> cnt == '0);
   a_r6_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg[7] |-> !wdog_rst_o);

   // R7: service restarts the count and masks a coinciding pulse
   a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      svc_i |=> cnt == '0);
   a_r7_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      svc_i |-> !wdog_rst_o);

   // R8: stop outcome follows the stop-enable bit
   a_r8_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_req_i && !cfg[5]) |=> (ill_rst_o && !stop_enter_o));
   a_r8_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_req_i && cfg[5]) |=> (stop_enter_o && !ill_rst_o));
endmodule

bind sysopt_guard sysopt_guard_chk #(.LONG_EXP(LONG_EXP)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sel_i       (sel_i),
   .wr_i        (wr_i),
   .svc_i       (svc_i),
   .stop_req_i  (stop_req_i),
   .rdata_o     (rdata_o),
   .wdog_rst_o  (wdog_rst_o),
   .ill_rst_o   (ill_rst_o),
   .stop_enter_o(stop_enter_o),
   .cfg         (cfg_q),
   .locked      (lock_q),
   .cnt         (wd_cnt)
);

// File: tb/sysopt_guard_test.sv
module sysopt_guard_test;
   localparam int SE = 4;
   localparam int LE = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, svc = 1'b0, stop = 1'b0;
   logic [7:0] wd = 8'h00;
   logic [7:0] rdata;
   logic       wdog, ill, stp, dbg;

   int n_run = 0, n_fail = 0, pulses = 0;

   logic [7:0] m_reg;
   logic       m_lock, m_ill, m_stp;
   int         m_cnt;

   sysopt_guard #(.SHORT_EXP(SE), .LONG_EXP(LE)) uut (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
      .wdata_i(wd), .rdata_o(rdata), .svc_i(svc), .stop_req_i(stop),
      .wdog_rst_o(wdog), .ill_rst_o(ill), .stop_enter_o(stp),
      .dbg_pin_sel_o(dbg));

   always #10 clk = ~clk;

   task automatic chk(input int act, input int exp, input string tag);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int term_of(input logic lng);
      return lng ? (1 << LE) - 1 : (1 << SE) - 1;
   endfunction

   task automatic model_reset();
      m_reg = 8'hC2; m_lock = 1'b0; m_cnt = 0; m_ill = 1'b0; m_stp = 1'b0;
   endtask

   task automatic compare_all();
      logic e_wd;
      e_wd = rst_n && m_reg[7] && !svc && (m_cnt >= term_of(m_reg[6]));
      chk(rdata, (sel && rd) ? (m_reg & 8'hF3) : 0, "R10 rdata");
      chk(wdog, e_wd, "R5 wdog_rst");
      chk(ill, m_ill, "R8 ill_rst");
      chk(stp, m_stp, "R8 stop_enter");
      chk(dbg, m_reg[1], "R9 dbg_pin_sel");
      if (wdog) pulses++;
   endtask

   task automatic edge_step();
      @(posedge clk);
      if (rst_n) begin
         m_ill = stop && !m_reg[5];
         m_stp = stop && m_reg[5];
         if (!m_reg[7] || svc || m_cnt >= term_of(m_reg[6])) m_cnt = 0;
         else m_cnt++;
         if (sel && wr && !m_lock) begin
            m_reg = wd; m_lock = 1'b1;
         end
      end
      @(negedge clk);
   endtask

   task automatic tick();
      #5; compare_all(); edge_step();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic do_write(input logic [7:0] v);
      sel = 1; wr = 1; wd = v; tick(); sel = 0; wr = 0;
   endtask

   task automatic do_read(input int exp, input string tag);
      sel = 1; rd = 1; #5;
      chk(rdata, exp, tag);
      compare_all(); edge_step();
      sel = 0; rd = 0;
   endtask

   task automatic apply_reset();
      rst_n = 0; model_reset(); ticks(2); rst_n = 1;
   endtask

   initial begin
      #4_000_000;
      n_fail++; n_run++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      apply_reset();
      // R1: reset value, R9: debug pin default
      chk(dbg, 1, "R9 dbg after reset");
      pulses = 0;
      ticks(256);
      chk(pulses, 2, "R5 long timeout pulse count");
      do_read(8'hC2, "R1 reset value");
      // R7: periodic service keeps watchdog quiet
      pulses = 0;
      for (int k = 0; k < 3; k++) begin ticks(99); svc = 1; tick(); svc = 0; end
      chk(pulses, 0, "R7 serviced no pulse");
      // R7: service exactly at terminal count
      while (m_cnt != term_of(1'b1)) tick();
      svc = 1; tick(); svc = 0;
      chk(pulses, 0, "R7 service at terminal suppresses");
      // R8: stop request while disabled, in same cycle as write enabling stop
      sel = 1; wr = 1; wd = 8'h3F; stop = 1; tick(); sel = 0; wr = 0; stop = 0;
      #5; chk(ill, 1, "R8 old value gives illegal reset"); compare_all(); edge_step();
      // R2, R3, R4: stored 0x3F reads 0x33
      do_read(8'h33, "R3 R4 stored value");
      stop = 1; tick(); stop = 0;
      #5; chk(stp, 1, "R8 stop allowed"); compare_all(); edge_step();
      // R6: watchdog disabled
      pulses = 0; ticks(300);
      chk(pulses, 0, "R6 disabled no pulse");
      // R2: later write ignored
      do_write(8'hC0);
      do_read(8'h33, "R2 second write ignored");
      // R11: reset clears lock; R2 lock even with default value
      apply_reset();
      do_read(8'hC2, "R11 reset restores");
      do_write(8'hC2);
      do_write(8'h00);
      do_read(8'hC2, "R2 lock on same value");
      // R5 short, R9 pin off
      apply_reset();
      do_write(8'h81);
      chk(dbg, 0, "R9 dbg cleared");
      pulses = 0; ticks(40);
      chk(pulses, 2, "R5 short timeout pulse count");
      // R11: write during reset discarded
      rst_n = 0; model_reset(); sel = 1; wr = 1; wd = 8'h00; ticks(2);
      sel = 0; wr = 0; rst_n = 1;
      chk(dbg, 1, "R9 reset returns pin");
      do_read(8'hC2, "R11 write in reset discarded");
      do_write(8'h11);
      do_read(8'h11, "R11 first write after reset taken");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule